// File: doc/BRIEF.md
# Variable-Length Frame SPI Master

This block is the serial engine of an SPI master. Bytes to send arrive on a transmit valid/ready interface. Each byte carries a flag that marks it as the final byte of its frame. The engine drives the serial clock, one slave select and the MOSI line. It samples MISO and hands each completed receive byte out on a valid/ready interface. The clock idle level, the clock phase and the select polarity can be chosen independently. The serial clock period is twice a programmable number of system clocks.

A frame's length need not be a multiple of the byte width. A tail-length setting gives the number of bits carried by the flagged final byte. Those bits are taken from the top of the transmit byte, and they arrive at the bottom of the receive byte. A frame closes cleanly after its flagged byte. If a byte without the flag finishes and no further transmit data is waiting, the frame is cut short and a sticky underrun flag is raised. A receive byte that is overwritten before it was taken raises a sticky overrun flag. A one-cycle clear pulse drops both flags.

Top module: `spi_frame_master`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `sck` equals `cfg_cpol`, `ss_out` is at its inactive level, `rx_valid` and both error flags are 0, and `tx_ready` is 1.
- R2: Each `sck` half period lasts `cfg_half_div` system clocks (`cfg_half_div` is at least 1). Between frames `sck` rests at `cfg_cpol` and does not toggle.
- R3: Slave select is active when `ss_out` equals `cfg_ss_inv`, so it is active low when `cfg_ss_inv`=0. It asserts the cycle after the first byte of a frame is accepted, stays active across byte boundaries, and releases one half period after the last clock edge. A frame of B bits therefore keeps select active for `cfg_half_div`*(2B+2) cycles.
- R4: Bits leave MSB first, with bit 7 leading, and a full byte makes 16 `sck` edges. The receive byte holds the first sampled MISO bit in its highest used position.
- R5: With `cfg_cpha`=0, MOSI is valid before the first edge of each bit, and MISO is sampled on the leading (odd-numbered) edge. With `cfg_cpha`=1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R6: `cfg_tail`=0 means every byte carries 8 bits. A value n from 1 to 7 makes the byte flagged by `tx_last` carry n bits, sent from `tx_data[7:8-n]`, with the received bits delivered in `rx_data[n-1:0]` and the upper bits zero.
- R7: A frame whose final byte carries `tx_last`=1 ends without raising either error flag.
- R8: If a byte with `tx_last`=0 finishes while `tx_valid` is low, the frame stops after that byte. The byte's receive value is still delivered, and `err_underrun` becomes 1 and stays 1.
- R9: `rx_valid` stays high until `rx_ready` is seen. A new receive byte arriving while the previous one is untaken replaces it and sets sticky `err_overrun`.
- R10: A one-cycle `err_clear` pulse returns both error flags to 0.
- R11: A next byte that is offered while the current one runs is accepted at the current byte's last edge, and the clock continues with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Clock phase: 0 samples on leading edge, 1 on trailing edge |
| cfg_ss_inv | input | 1 | Select polarity: 0 active low, 1 active high |
| cfg_half_div | input | DIV_W | System clocks per serial clock half period, at least 1 |
| cfg_tail | input | TAIL_W | Bits in a frame's flagged final byte, 0 meaning a full byte |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit byte accepted this cycle when valid |
| tx_data | input | WORD_W | Transmit byte, MSB first |
| tx_last | input | 1 | Marks the offered byte as final in its frame |
| rx_valid | output | 1 | Receive byte available |
| rx_ready | input | 1 | Receive byte taken |
| rx_data | output | WORD_W | Receive byte, right-justified |
| err_clear | input | 1 | One-cycle pulse clearing both error flags |
| err_underrun | output | 1 | Sticky: data ran out without an end flag |
| err_overrun | output | 1 | Sticky: receive byte overwritten before it was taken |
| sck | output | 1 | Serial clock |
| ss_out | output | 1 | Slave select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions assume that the configuration inputs change only while the select is inactive. They also assume that `cfg_half_div` is never 0 and that `tx_data` and `tx_last` hold steady while a byte is offered. The bench changes settings only between frames, and after each change it waits a few cycles. It offers a byte at a falling edge and holds it until it sees `tx_ready`. MISO is looped back from MOSI through an optional inversion, so every expected receive byte and every frame length follows from the bytes that were offered.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LEAD,
      ST_XFER,
      ST_TRAIL
   } spi_state_e;

   localparam int FLAG_UNDERRUN = 0;
   localparam int FLAG_OVERRUN  = 1;
   localparam int FLAG_COUNT    = 2;
endpackage

// File: rtl/spi_frame_clkdiv.sv
module spi_frame_clkdiv #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             run,
   input  logic [DIV_W-1:0] half_cycles,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q == half_cycles - DIV_W'(1));

   always_ff @(posedge clk) begin
      if (rst || !run) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cpha,
   input  logic              load,
   input  logic [WORD_W-1:0] load_word,
   input  logic              lead_edge,
   input  logic              trail_edge,
   input  logic              final_edge,
   input  logic              miso,
   output logic              mosi,
   output logic [WORD_W-1:0] rx_word
);
   logic [WORD_W-1:0] tx_sh;
   logic [WORD_W-1:0] rx_sh;
   logic              mosi_q;
   logic              drive_ev;
   logic              sample_ev;

   // phase 0: present early, sample on leading edge; phase 1: the reverse
   assign drive_ev  = cpha ? lead_edge : (trail_edge && !final_edge);
   assign sample_ev = cpha ? trail_edge : lead_edge;
   assign rx_word   = sample_ev ? {rx_sh[WORD_W-2:0], miso} : rx_sh;
   assign mosi      = mosi_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         tx_sh  <= '0;
         mosi_q <= 1'b0;
      end else if (load) begin
         if (cpha) begin
            tx_sh <= load_word;
         end else begin
            tx_sh  <= {load_word[WORD_W-2:0], 1'b0};
            mosi_q <= load_word[WORD_W-1];
         end
      end else if (drive_ev) begin
         mosi_q <= tx_sh[WORD_W-1];
         tx_sh  <= {tx_sh[WORD_W-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk) begin
      if (rst || load) begin
         rx_sh <= '0;
      end else if (sample_ev) begin
         rx_sh <= rx_word;
      end
   end
endmodule

// File: rtl/spi_frame_flags.sv
module spi_frame_flags #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clear,
   input  logic [N-1:0] set,
   output logic [N-1:0] flags
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      logic flag_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            flag_q <= 1'b0;
         end else if (set[i]) begin
            flag_q <= 1'b1;
         end else if (clear) begin
            flag_q <= 1'b0;
         end
      end
      assign flags[i] = flag_q;
   end
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
   import spi_frame_pkg::*;
#(
   parameter int WORD_W = 8,
   parameter int DIV_W  = 8,
   parameter int TAIL_W = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_cpol,
   input  logic              cfg_cpha,
   input  logic              cfg_ss_inv,
   input  logic [DIV_W-1:0]  cfg_half_div,
   input  logic [TAIL_W-1:0] cfg_tail,
   input  logic              tx_valid,
   output logic              tx_ready,
   input  logic [WORD_W-1:0] tx_data,
   input  logic              tx_last,
   output logic              rx_valid,
   input  logic              rx_ready,
   output logic [WORD_W-1:0] rx_data,
   input  logic              err_clear,
   output logic              err_underrun,
   output logic              err_overrun,
   output logic              sck,
   output logic              ss_out,
   output logic              mosi,
   input  logic              miso
);
   localparam int CNT_W  = $clog2(WORD_W + 1);
   localparam int LIM_W  = CNT_W + 1;
   localparam int EDGE_W = $clog2(2 * WORD_W);

   if (WORD_W < 2) begin : g_bad_word
      $error("spi_frame_master: WORD_W must be at least 2");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("spi_frame_master: DIV_W must be at least 1");
   end
   if (TAIL_W < $clog2(WORD_W)) begin : g_bad_tail
      $error("spi_frame_master: TAIL_W too narrow for WORD_W");
   end

   spi_state_e        state_q;
   logic              cur_last_q;
   logic [EDGE_W-1:0] edge_cnt_q;
   logic              sck_q;
   logic              rx_valid_q;
   logic [WORD_W-1:0] rx_data_q;

   logic              tick;
   logic              xfer_tick;
   logic              lead_edge;
   logic              trail_edge;
   logic              byte_done;
   logic              accept;
   logic              carry_on;
   logic [CNT_W-1:0]  byte_bits;
   logic [LIM_W-1:0]  bits_x2;
   logic [EDGE_W-1:0] edge_lim;
   logic [WORD_W-1:0] rx_word;
   logic [FLAG_COUNT-1:0] flag_set;
   logic [FLAG_COUNT-1:0] flag_q;
   logic              ss_active;

   assign byte_bits = (cur_last_q && (cfg_tail != '0)) ? CNT_W'(cfg_tail) : CNT_W'(WORD_W);
   assign bits_x2   = {byte_bits, 1'b0};
   assign edge_lim  = EDGE_W'(bits_x2 - LIM_W'(1));

   assign xfer_tick  = (state_q == ST_XFER) && tick;
   assign lead_edge  = xfer_tick && !edge_cnt_q[0];
   assign trail_edge = xfer_tick && edge_cnt_q[0];
   assign byte_done  = xfer_tick && (edge_cnt_q == edge_lim);

   assign tx_ready = (state_q == ST_IDLE) || (byte_done && !cur_last_q);
   assign accept   = tx_valid && tx_ready;
   assign carry_on = byte_done && !cur_last_q && tx_valid;

   spi_frame_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk         (clk),
      .rst         (rst),
      .run         (state_q != ST_IDLE),
      .half_cycles (cfg_half_div),
      .tick        (tick)
   );

   spi_frame_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk        (clk),
      .rst        (rst),
      .cpha       (cfg_cpha),
      .load       (accept),
      .load_word  (tx_data),
      .lead_edge  (lead_edge),
      .trail_edge (trail_edge),
      .final_edge (byte_done),
      .miso       (miso),
      .mosi       (mosi),
      .rx_word    (rx_word)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q    <= ST_IDLE;
         cur_last_q <= 1'b0;
         edge_cnt_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               edge_cnt_q <= '0;
               if (accept) begin
                  cur_last_q <= tx_last;
                  state_q    <= ST_LEAD;
               end
            end
            ST_LEAD: begin
               if (tick) state_q <= ST_XFER;
            end
            ST_XFER: begin
               if (byte_done) begin
                  edge_cnt_q <= '0;
                  if (carry_on) begin
                     cur_last_q <= tx_last;
                  end else begin
                     state_q <= ST_TRAIL;
                  end
               end else if (tick) begin
                  edge_cnt_q <= edge_cnt_q + EDGE_W'(1);
               end
            end
            ST_TRAIL: begin
               if (tick) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst || state_q == ST_IDLE) begin
         sck_q <= cfg_cpol;
      end else if (xfer_tick) begin
         sck_q <= ~sck_q;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rx_valid_q <= 1'b0;
         rx_data_q  <= '0;
      end else if (byte_done) begin
         rx_valid_q <= 1'b1;
         rx_data_q  <= rx_word;
      end else if (rx_ready) begin
         rx_valid_q <= 1'b0;
      end
   end

   assign flag_set[FLAG_UNDERRUN] = byte_done && !cur_last_q && !tx_valid;
   assign flag_set[FLAG_OVERRUN]  = byte_done && rx_valid_q && !rx_ready;

   spi_frame_flags #(.N(FLAG_COUNT)) u_flags (
      .clk   (clk),
      .rst   (rst),
      .clear (err_clear),
      .set   (flag_set),
      .flags (flag_q)
   );

   assign ss_active    = (state_q != ST_IDLE);
   assign ss_out       = cfg_ss_inv ? ss_active : ~ss_active;
   assign sck          = sck_q;
   assign rx_valid     = rx_valid_q;
   assign rx_data      = rx_data_q;
   assign err_underrun = flag_q[FLAG_UNDERRUN];
   assign err_overrun  = flag_q[FLAG_OVERRUN];
endmodule

// File: rtl/spi_frame_master_chk.sv
module spi_frame_master_chk (
   input logic clk,
   input logic rst,
   input logic cfg_cpol,
   input logic cfg_ss_inv,
   input logic sck,
   input logic ss_out,
   input logic tx_valid,
   input logic tx_ready,
   input logic rx_valid,
   input logic rx_ready,
   input logic err_clear,
   input logic err_underrun,
   input logic err_overrun
);
   logic act;
   assign act = (ss_out == cfg_ss_inv);

   assert_reset_state_R1: assert property (@(posedge clk)
      rst |=> (!rx_valid && !err_underrun && !err_overrun));

   assert_idle_ready_R1: assert property (@(posedge clk) disable iff (rst)
      (!act && $past(!act) && $stable(cfg_ss_inv)) |-> tx_ready);

   assert_sck_rest_R2: assert property (@(posedge clk) disable iff (rst)
      (!act && $past(!act) && $stable(cfg_cpol) && $stable(cfg_ss_inv)) |-> (sck == cfg_cpol));

   assert_select_held_R3: assert property (@(posedge clk) disable iff (rst)
      (tx_valid && tx_ready && act && $stable(cfg_ss_inv)) |=> act);

   assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      (err_underrun && !err_clear) |=> err_underrun);

   assert_rx_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (rx_valid && !rx_ready) |=> rx_valid);

   assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      (err_overrun && !err_clear) |=> err_overrun);
endmodule

bind spi_frame_master spi_frame_master_chk u_chk (
   .clk          (clk),
   .rst          (rst),
   .cfg_cpol     (cfg_cpol),
   .cfg_ss_inv   (cfg_ss_inv),
   .sck          (sck),
   .ss_out       (ss_out),
   .tx_valid     (tx_valid),
   .tx_ready     (tx_ready),
   .rx_valid     (rx_valid),
   .rx_ready     (rx_ready),
   .err_clear    (err_clear),
   .err_underrun (err_underrun),
   .err_overrun  (err_overrun)
);

// File: tb/spi_frame_master_test.sv
`timescale 1ns/1ps
module spi_frame_master_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cfg_cpol = 1'b0;
   logic       cfg_cpha = 1'b0;
   logic       cfg_ss_inv = 1'b0;
   logic [7:0] cfg_half_div = 8'd1;
   logic [2:0] cfg_tail = 3'd0;
   logic       tx_valid = 1'b0;
   logic       tx_ready;
   logic [7:0] tx_data = 8'd0;
   logic       tx_last = 1'b0;
   logic       rx_valid;
   logic       rx_ready = 1'b1;
   logic [7:0] rx_data;
   logic       err_clear = 1'b0;
   logic       err_underrun;
   logic       err_overrun;
   logic       sck;
   logic       ss_out;
   logic       mosi;
   logic       flip = 1'b0;
   logic       miso;

   assign miso = mosi ^ flip;

   always #2 clk = ~clk;

   spi_frame_master uut (
      .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
      .cfg_ss_inv(cfg_ss_inv), .cfg_half_div(cfg_half_div), .cfg_tail(cfg_tail),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
      .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
      .err_clear(err_clear), .err_underrun(err_underrun), .err_overrun(err_overrun),
      .sck(sck), .ss_out(ss_out), .mosi(mosi), .miso(miso)
   );

   int checks = 0;
   int failures = 0;
   bit done = 0;
   bit mon_en = 1;

   logic [7:0] rx_exp_q[$];
   int         edge_exp_q[$];
   int         dur_exp_q[$];
   logic [7:0] frame_bytes[8];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // receive scoreboard
   always @(negedge clk) begin
      if (mon_en && !rst && rx_valid && rx_ready) begin
         if (rx_exp_q.size() == 0) begin
            check(1'b0, "R4 unexpected rx byte", int'(rx_data), -1);
         end else begin
            logic [7:0] e;
            e = rx_exp_q.pop_front();
            check(rx_data == e, "R4/R6 rx byte", int'(rx_data), int'(e));
         end
      end
   end

   // frame monitor: edges and select duration
   logic prev_sck = 1'b0;
   bit   prev_act = 0;
   int   edge_n = 0;
   int   dur_n = 0;
   always @(negedge clk) begin
      bit a;
      a = (ss_out == cfg_ss_inv) && !rst;
      if (a) begin
         dur_n++;
         if (sck != prev_sck) edge_n++;
      end
      if (prev_act && !a) begin
         if (edge_exp_q.size() == 0) begin
            check(1'b0, "R3 unexpected frame", edge_n, -1);
         end else begin
            int ee;
            int de;
            ee = edge_exp_q.pop_front();
            de = dur_exp_q.pop_front();
            check(edge_n == ee, "R4/R6 sck edge count", edge_n, ee);
            check(dur_n == de, "R2/R3/R11 select active cycles", dur_n, de);
         end
         edge_n = 0;
         dur_n = 0;
      end
      prev_act = a;
      prev_sck = sck;
   end

   // driver: sends nb bytes of frame_bytes; end_flag marks the final one
   task automatic run_frame(input int nb, input bit end_flag, input bit push_rx);
      int total = 0;
      for (int i = 0; i < nb; i++) begin
         bit fin;
         int bits;
         logic [7:0] m;
         fin = (i == nb - 1) && end_flag;
         bits = (fin && cfg_tail != 0) ? int'(cfg_tail) : 8;
         @(negedge clk);
         tx_valid = 1'b1;
         tx_data  = frame_bytes[i];
         tx_last  = fin;
         while (!tx_ready) @(negedge clk);
         m = (frame_bytes[i] ^ (flip ? 8'hFF : 8'h00)) >> (8 - bits);
         if (push_rx) rx_exp_q.push_back(m);
         total += bits;
      end
      @(negedge clk);
      tx_valid = 1'b0;
      tx_last  = 1'b0;
      edge_exp_q.push_back(2 * total);
      dur_exp_q.push_back(int'(cfg_half_div) * (2 * total + 2));
      while (ss_out == cfg_ss_inv) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic set_cfg(input bit cp, input bit ph, input bit inv, input int dv, input int tl, input bit fl);
      @(negedge clk);
      cfg_cpol = cp;
      cfg_cpha = ph;
      cfg_ss_inv = inv;
      cfg_half_div = 8'(dv);
      cfg_tail = 3'(tl);
      flip = fl;
      repeat (3) @(negedge clk);
   endtask

   task automatic pulse_clear();
      @(negedge clk);
      err_clear = 1'b1;
      @(negedge clk);
      err_clear = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state, during reset
      check(sck == 1'b0, "R1 sck idle in reset", int'(sck), 0);
      check(ss_out == 1'b1, "R1 select inactive in reset", int'(ss_out), 1);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(rx_valid == 1'b0, "R1 rx_valid after reset", int'(rx_valid), 0);
      check(err_underrun == 1'b0 && err_overrun == 1'b0, "R1 flags after reset",
            int'({err_underrun, err_overrun}), 0);
      check(tx_ready == 1'b1, "R1 tx_ready after reset", int'(tx_ready), 1);

      // R4 R5 R7 R11: mode 0, three full bytes, continuous
      set_cfg(0, 0, 0, 1, 0, 0);
      frame_bytes[0] = 8'hA5; frame_bytes[1] = 8'h3C; frame_bytes[2] = 8'h81;
      run_frame(3, 1, 1);
      check(!err_underrun && !err_overrun, "R7 no error after flagged end",
            int'({err_underrun, err_overrun}), 0);

      // R6 R5: phase 1, 20-bit frame (tail 4), inverted loopback
      set_cfg(0, 1, 0, 2, 4, 1);
      frame_bytes[0] = 8'hF0; frame_bytes[1] = 8'h5A; frame_bytes[2] = 8'hC3;
      run_frame(3, 1, 1);

      // R2: clock idle high, tail 3, one byte, slower divider
      set_cfg(1, 0, 0, 3, 3, 0);
      check(sck == 1'b1, "R2 sck rests at cpol=1", int'(sck), 1);
      frame_bytes[0] = 8'hB7;
      run_frame(1, 1, 1);
      check(sck == 1'b1, "R2 sck rests at cpol=1 after frame", int'(sck), 1);

      // R5 R6: cpol 1, phase 1, tail 1, two bytes
      set_cfg(1, 1, 0, 1, 1, 0);
      frame_bytes[0] = 8'h69; frame_bytes[1] = 8'h80;
      run_frame(2, 1, 1);

      // R3: inverted select polarity, phase 0, tail 7
      set_cfg(0, 0, 1, 2, 7, 1);
      check(ss_out == 1'b0, "R3 inverted select idles low", int'(ss_out), 0);
      frame_bytes[0] = 8'h1E; frame_bytes[1] = 8'hD2;
      run_frame(2, 1, 1);
      check(ss_out == 1'b0, "R3 inverted select back low", int'(ss_out), 0);

      // R8: two bytes without end flag, then data runs out
      set_cfg(0, 0, 0, 1, 0, 0);
      frame_bytes[0] = 8'h47; frame_bytes[1] = 8'h9B;
      run_frame(2, 0, 1);
      check(err_underrun == 1'b1, "R8 underrun raised", int'(err_underrun), 1);
      check(err_overrun == 1'b0, "R8 no overrun", int'(err_overrun), 0);
      repeat (5) @(negedge clk);
      check(err_underrun == 1'b1, "R8 underrun sticky", int'(err_underrun), 1);
      pulse_clear();
      check(err_underrun == 1'b0, "R10 clear drops underrun", int'(err_underrun), 0);

      // R9: receive side stalled, second byte overwrites first
      mon_en = 0;
      rx_ready = 1'b0;
      frame_bytes[0] = 8'h11; frame_bytes[1] = 8'hE4;
      run_frame(2, 1, 0);
      check(rx_valid == 1'b1, "R9 rx_valid held", int'(rx_valid), 1);
      check(rx_data == 8'hE4, "R9 newest byte kept", int'(rx_data), 32'hE4);
      check(err_overrun == 1'b1, "R9 overrun raised", int'(err_overrun), 1);
      @(negedge clk);
      rx_ready = 1'b1;
      @(negedge clk);
      check(rx_valid == 1'b0, "R9 rx_valid drops after ready", int'(rx_valid), 0);
      pulse_clear();
      check(err_overrun == 1'b0, "R10 clear drops overrun", int'(err_overrun), 0);
      mon_en = 1;

      repeat (5) @(negedge clk);
      check(rx_exp_q.size() == 0, "R4 all rx bytes seen", rx_exp_q.size(), 0);
      check(edge_exp_q.size() == 0, "R3 all frames seen", edge_exp_q.size(), 0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule